// File: doc/BRIEF.md
# Base-Delta-Immediate Line Decompressor

This block turns one compressed cache line back into its 32-byte original. A compressed line arrives as a 4-bit format code, a per-element base-select mask and a packed image of up to 32 bytes. For the arithmetic formats, the image holds one explicit base followed by a run of narrow deltas. Each delta is sign-extended to the element width. A per-element mask bit then adds either the stored base or an implicit zero to it. All lanes compute in parallel as a single vector addition.

Three further codes skip the adders: an all-zero line, a line made of one repeated 8-byte value, and an uncompressed line that is passed through as it is. Both sides of the block use a valid/ready handshake. The result is held in an output register, one cycle after the input is accepted.

Top module: `bdi_decomp`

## Requirements
- R1: After reset `outValid` is low and `inReady` is high.
- R2: An input is accepted on a clock edge where `inValid` and `inReady` are both high. The decoded line appears on `outLine` with `outValid` high from the next edge.
- R3: While `outValid` is high and `outReady` is low, `outValid` stays high, `outLine` stays unchanged and `inReady` is low.
- R4: `inReady` equals `!outValid || outReady`. A consumed output therefore allows a new line to be accepted on the same edge, giving one line per cycle.
- R5: Code 0 (zero line) produces an all-zero `outLine`, whatever `inData` and `inMask` hold.
- R6: Code 1 (repeated value) copies `inData[63:0]` into all four 8-byte elements of `outLine`.
- R7: Codes 8 to 15 (uncompressed) pass `inData` to `outLine` unchanged.
- R8: Codes 2 to 7 select the arithmetic formats, written as (base bytes, delta bytes): 2=(8,1), 3=(8,2), 4=(8,4), 5=(4,1), 6=(4,2), 7=(2,1).
- R9: For an arithmetic format with base size B and delta size D, the image is laid out little-endian. The base sits in bytes 0..B-1 and delta i sits in bytes B+i*D..B+i*D+D-1. Output element i occupies `outLine` bytes i*B..i*B+B-1, and the line has 32/B elements.
- R10: Each delta is sign-extended to the element width, and the sum wraps modulo 2^(8*B).
- R11: When mask bit i is 1, element i adds the base. When it is 0, element i adds zero. Mask bits at or above the element count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Compressed line offered |
| inReady | output | 1 | Block can take a line this cycle |
| inCode | input | 4 | Format code |
| inMask | input | 16 | Per-element base select, bit i for element i |
| inData | input | 256 | Packed compressed image |
| outValid | output | 1 | `outLine` holds a decoded line |
| outReady | input | 1 | Consumer takes the line this cycle |
| outLine | output | 256 | Decompressed 32-byte line |

## Verification
The bench builds the block at its default 32-byte line. At that size the full mask is 16 bits, all six arithmetic formats exist, and all sixteen code values can be driven. For every format, the bench acts as a compressor: it builds original lines from random bases and offsets and packs them into images. It forces offsets to the signed extremes (most positive, most negative and minus one) and uses an all-ones base, so that sign extension and wraparound are exercised in every lane width. Random mask bits above each format's element count check that those bits are ignored. Separate sequences drive back-to-back transfers and a stalled consumer.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

  typedef enum logic [3:0] {
    CODE_ZERO = 4'd0,
    CODE_REP  = 4'd1,
    CODE_B8D1 = 4'd2,
    CODE_B8D2 = 4'd3,
    CODE_B8D4 = 4'd4,
    CODE_B4D1 = 4'd5,
    CODE_B4D2 = 4'd6,
    CODE_B2D1 = 4'd7,
    CODE_RAW  = 4'd8
  } code_e;

  localparam int NUM_FMT = 6;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_REP  = 2'd1,
    SEL_BD   = 2'd2,
    SEL_RAW  = 2'd3
  } outSel_e;

  typedef struct packed {
    logic    load;
    outSel_e sel;
    logic [2:0] fmt;
  } strobes_t;

  // Base size in bytes of arithmetic format f (f = code - 2).
  function automatic int fmtBase(int f);
    case (f)
      0, 1, 2: return 8;
      3, 4:    return 4;
      default: return 2;
    endcase
  endfunction

  // Delta size in bytes of arithmetic format f.
  function automatic int fmtDelta(int f);
    case (f)
      1, 4:    return 2;
      2:       return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/bdi_expand.sv
module bdi_expand #(
  parameter int LINE_BYTES  = 32,
  parameter int ELEM_BYTES  = 8,
  parameter int DELTA_BYTES = 1,
  localparam int NUM_ELEM   = LINE_BYTES / ELEM_BYTES,
  localparam int ELEM_W     = ELEM_BYTES * 8,
  localparam int DELTA_W    = DELTA_BYTES * 8,
  localparam int IMG_W      = ELEM_W + NUM_ELEM * DELTA_W,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic [IMG_W-1:0]    img,
  input  logic [NUM_ELEM-1:0] useBase,
  output logic [LINE_W-1:0]   line
);

  logic [ELEM_W-1:0] base;
  assign base = img[ELEM_W-1:0];

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
    logic [DELTA_W-1:0] delta;
    logic [ELEM_W-1:0]  deltaExt;
    logic [ELEM_W-1:0]  addend;
    assign delta    = img[ELEM_W + i*DELTA_W +: DELTA_W];
    assign deltaExt = {{(ELEM_W-DELTA_W){delta[DELTA_W-1]}}, delta};
    assign addend   = useBase[i] ? base : '0;
    assign line[i*ELEM_W +: ELEM_W] = deltaExt + addend;
  end

endmodule

// File: rtl/bdi_ctrl.sv
module bdi_ctrl
  import bdi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] inCode,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output strobes_t   strb
);

  logic accept;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN)         outValid <= 1'b0;
    else if (accept)   outValid <= 1'b1;
    else if (outReady) outValid <= 1'b0;
  end

  always_comb begin
    strb.load = accept;
    strb.fmt  = '0;
    case (inCode)
      CODE_ZERO: strb.sel = SEL_ZERO;
      CODE_REP:  strb.sel = SEL_REP;
      CODE_B8D1, CODE_B8D2, CODE_B8D4,
      CODE_B4D1, CODE_B4D2, CODE_B2D1: begin
        strb.sel = SEL_BD;
        strb.fmt = 3'(inCode - 4'd2);
      end
      default:   strb.sel = SEL_RAW;
    endcase
  end

endmodule

// File: rtl/bdi_datapath.sv
module bdi_datapath
  import bdi_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int REP_BYTES  = 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int MASK_W    = LINE_BYTES / 2,
  localparam int REP_W     = REP_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [LINE_W-1:0] inData,
  input  logic [MASK_W-1:0] inMask,
  output logic [LINE_W-1:0] lineQ
);

  logic [LINE_W-1:0] cand [8];
  logic [LINE_W-1:0] lineD;

  for (genvar f = 0; f < 8; f++) begin : g_fmt
    if (f < NUM_FMT) begin : g_used
      localparam int EB    = fmtBase(f);
      localparam int DB    = fmtDelta(f);
      localparam int NE    = LINE_BYTES / EB;
      localparam int IMG_W = (EB + NE * DB) * 8;
      bdi_expand #(
        .LINE_BYTES (LINE_BYTES),
        .ELEM_BYTES (EB),
        .DELTA_BYTES(DB)
      ) u_expand (
        .img    (inData[IMG_W-1:0]),
        .useBase(inMask[NE-1:0]),
        .line   (cand[f])
      );
    end else begin : g_spare
      assign cand[f] = '0;
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_ZERO: lineD = '0;
      SEL_REP:  lineD = {(LINE_BYTES/REP_BYTES){inData[REP_W-1:0]}};
      SEL_BD:   lineD = cand[strb.fmt];
      default:  lineD = inData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          lineQ <= '0;
    else if (strb.load) lineQ <= lineD;
  end

endmodule

// File: rtl/bdi_decomp.sv
module bdi_decomp
  import bdi_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int REP_BYTES  = 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int MASK_W    = LINE_BYTES / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [3:0]        inCode,
  input  logic [MASK_W-1:0] inMask,
  input  logic [LINE_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [LINE_W-1:0] outLine
);

  strobes_t strb;

  bdi_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inCode  (inCode),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strb    (strb)
  );

  bdi_datapath #(
    .LINE_BYTES(LINE_BYTES),
    .REP_BYTES (REP_BYTES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .inData(inData),
    .inMask(inMask),
    .lineQ (outLine)
  );

endmodule

// File: rtl/bdi_decomp_checker.sv
module bdi_decomp_checker #(
  parameter int LINE_BYTES = 32,
  parameter int REP_BYTES  = 8,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int MASK_W    = LINE_BYTES / 2,
  localparam int REP_W     = REP_BYTES * 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [3:0]        inCode,
  input logic [MASK_W-1:0] inMask,
  input logic [LINE_W-1:0] inData,
  input logic              outValid,
  input logic              outReady,
  input logic [LINE_W-1:0] outLine
);

  logic acc;
  assign acc = inValid && inReady;

  p_accept_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> outValid);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outLine)));

  p_stall_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  p_ready_rule_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid || outReady) |-> inReady);

  p_zero_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    (acc && inCode == 4'd0) |=> (outLine == '0));

  p_rep_line_r6: assert property (@(posedge clk) disable iff (!rstN)
    (acc && inCode == 4'd1) |=> (outLine == {(LINE_BYTES/REP_BYTES){$past(inData[REP_W-1:0])}}));

  p_raw_line_r7: assert property (@(posedge clk) disable iff (!rstN)
    (acc && inCode[3]) |=> (outLine == $past(inData)));

endmodule

bind bdi_decomp bdi_decomp_checker #(
  .LINE_BYTES(LINE_BYTES),
  .REP_BYTES (REP_BYTES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .inCode  (inCode),
  .inMask  (inMask),
  .inData  (inData),
  .outValid(outValid),
  .outReady(outReady),
  .outLine (outLine)
);

// File: tb/bdi_decomp_tb.sv
`timescale 1ns/1ps
module bdi_decomp_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [3:0]   inCode = '0;
  logic [15:0]  inMask = '0;
  logic [255:0] inData = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [255:0] outLine;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bdi_decomp dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCode(inCode), .inMask(inMask), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outLine(outLine)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rand256();
    logic [255:0] v = '0;
    for (int k = 0; k < 8; k++) v = (v << 32) | 256'($urandom);
    return v;
  endfunction

  function automatic logic [63:0] trunc(input logic [63:0] v, input int bytes);
    if (bytes >= 8) return v;
    return v & ((64'd1 << (bytes*8)) - 64'd1);
  endfunction

  function automatic logic [63:0] sext(input logic [63:0] v, input int bytes);
    logic [63:0] m;
    if (bytes >= 8) return v;
    m = (64'd1 << (bytes*8)) - 64'd1;
    return v[bytes*8-1] ? (v | ~m) : (v & m);
  endfunction

  // Send one line with the consumer ready and check the output one edge later.
  task automatic sendCheck(input logic [3:0] code, input logic [15:0] mask,
                           input logic [255:0] data, input logic [255:0] exp,
                           input string req);
    inCode = code; inMask = mask; inData = data; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R2 valid"}, 256'(outValid), 256'd1);
    check(req, outLine, exp);
  endtask

  // Compressor model: builds original elements from base/offset, packs the image.
  task automatic runFormat(input int code, input int eb, input int db, input int iter);
    int n;
    logic [63:0] base, off, elem;
    logic [255:0] img, exp;
    logic [15:0] mask;
    n = 32 / eb;
    base = trunc({$urandom, $urandom}, eb);
    if (iter % 5 == 4) base = trunc('1, eb);
    mask = 16'($urandom);
    img = 256'(base);
    exp = '0;
    for (int i = 0; i < n; i++) begin
      case ((iter + i) % 4)
        0: off = trunc({$urandom, $urandom}, db);
        1: off = trunc((64'd1 << (db*8-1)) - 64'd1, db);
        2: off = trunc(64'd1 << (db*8-1), db);
        default: off = trunc('1, db);
      endcase
      elem = trunc((mask[i] ? base : 64'd0) + sext(off, db), eb);
      exp |= 256'(elem) << (i*eb*8);
      img |= 256'(off) << ((eb + i*db)*8);
    end
    sendCheck(4'(code), mask, img, exp, "R8 R9 R10 R11 arith");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 outValid", 256'(outValid), 256'd0);
    check("R1 inReady", 256'(inReady), 256'd1);
    rstN = 1'b1;
    @(negedge clk);

    // R5: zero line ignores data and mask
    for (int k = 0; k < 4; k++)
      sendCheck(4'd0, 16'($urandom), rand256(), '0, "R5 zero");

    // R6: repeated value
    for (int k = 0; k < 4; k++) begin
      a = rand256();
      sendCheck(4'd1, 16'($urandom), a, {4{a[63:0]}}, "R6 repeat");
    end

    // R7: all uncompressed codes
    for (int c = 8; c < 16; c++) begin
      a = rand256();
      sendCheck(4'(c), 16'($urandom), a, a, "R7 raw");
    end

    // R8..R11: every arithmetic format, many patterns
    for (int it = 0; it < 40; it++) begin
      runFormat(2, 8, 1, it);
      runFormat(3, 8, 2, it);
      runFormat(4, 8, 4, it);
      runFormat(5, 4, 1, it);
      runFormat(6, 4, 2, it);
      runFormat(7, 2, 1, it);
    end

    // R4: back-to-back transfers
    a = rand256(); b = rand256();
    inCode = 4'd8; inData = a; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R4 first line", outLine, a);
    check("R4 ready while draining", 256'(inReady), 256'd1);
    inData = b;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check("R4 second line", outLine, b);
    check("R4 second valid", 256'(outValid), 256'd1);
    @(negedge clk);

    // R3: stalled consumer
    outReady = 1'b0;
    a = rand256(); b = rand256();
    inCode = 4'd8; inData = a; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inData = b; inCode = 4'd0;
    check("R3 blocked", 256'(inReady), 256'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 held line", outLine, a);
    check("R3 held valid", 256'(outValid), 256'd1);
    outReady = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check("R3 R5 after release", outLine, '0);
    @(posedge clk); @(negedge clk);
    check("R2 drained", 256'(outValid), 256'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule